// File: doc/BRIEF.md
# Multi-Channel Reloading Down-Counter Timer

This peripheral holds two or three independent 32-bit down-counters. Each channel has three registers: a reload value, a live counter and a 16-bit control word. A single shared byte of run bits starts and stops the channels. Each channel counts down once per prescaled tick of the peripheral clock. When it steps past zero, it reloads from its reload register and raises an underflow flag. Its level interrupt is high while that flag and the channel's interrupt enable are both set.

Software uses the block in two ways. It can load a delta, enable the interrupt and start the channel to get an event. It can also load all ones into both 32-bit registers and let the channel run free; inverting the counter value then gives a rising time base. The registers are reached over a plain memory-mapped bus with byte strobes. Reads are combinational. A parameter selects between the standard address layout and a legacy one.

Top module: `ch_down_timer`

## Requirements
- R1: The run byte holds one bit per channel, and bit n runs channel n. A channel whose bit is clear keeps its counter frozen. Run bits at or above NCH read as 0.
- R2: With LEGACY=0 the run byte is at byte address 4 and channel n starts at 8+12n. With LEGACY=1 the run byte is at 2 and channel n starts at 4+12n. Inside a channel, reload is at +0, counter at +4 and control at +8.
- R3: Writes honour the byte strobes. The control word keeps only bit 8 (underflow flag), bit 5 (interrupt enable) and bits 2:0 (prescaler code). All its other bits read as 0.
- R4: Prescaler code 0 divides the clock by 4, 1 by 16, 2 by 64, 3 by 256 and 4 by 1024. The first decrement falls on the divide-th clock edge after the edge that sets the run bit.
- R5: Prescaler codes 5, 6 and 7 stop the count.
- R6: A stopped channel's prescaler restarts from zero when the channel is started again.
- R7: A tick with the counter at 0 loads the reload value and sets the underflow flag.
- R8: irq[n] is high exactly while channel n has both its underflow flag and its interrupt enable set.
- R9: Writing 0 to control bit 8 clears the flag, and writing 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R10: A software write to the counter takes effect on the next edge, even while the channel runs. It overrides a decrement or reload in that cycle.
- R11: After reset the run bits and the control words are 0, irq is 0, and every reload and counter register holds 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address; bits AW-1:2 select the word |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data, lane aligned |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | NCH | Per-channel level interrupt |

## Verification
The assertions assume that every write lasts a single cycle and that bus_be is meaningful whenever bus_we is high. The counter-reload property further assumes that no write to the same counter lands in the underflow cycle. The stimulus meets both conditions: its write task raises the strobe for exactly one edge with fixed lane enables. Every counter value is read back only after the channel has been stopped, so combinational read data never races a tick.

// File: rtl/ch_down_timer.sv
module ch_down_timer #(
  parameter int NCH    = 3,
  parameter bit LEGACY = 1'b0,
  parameter int AW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [NCH-1:0] irq
);
  localparam int SS_OFF  = LEGACY ? 2 : 4;
  localparam int SS_WORD = SS_OFF / 4;
  localparam int SS_LANE = SS_OFF % 4;
  localparam int CH_BASE = LEGACY ? 4 : 8;
  localparam int CH_STEP = 12;
  localparam int WW      = AW - 2;

  function automatic logic [31:0] lanes(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction

  function automatic logic [9:0] psc_mask(input logic [2:0] code);
    case (code)
      3'd0:    return 10'd3;
      3'd1:    return 10'd15;
      3'd2:    return 10'd63;
      3'd3:    return 10'd255;
      3'd4:    return 10'd1023;
      default: return 10'd0;
    endcase
  endfunction

  logic [WW-1:0] word;
  assign word = bus_addr[AW-1:2];

  logic [NCH-1:0] run;
  logic           ss_wr;
  logic [NCH-1:0][31:0] reload_q, cnt_q;
  logic [NCH-1:0][9:0]  pre_q;
  logic [NCH-1:0][2:0]  psc_q;
  logic [NCH-1:0] ie_q, uf_q, tick, unf;
  logic [NCH-1:0] rl_wr, cnt_wr, ctl_lo_wr, ctl_hi_wr;

  assign ss_wr = bus_we && (word == WW'(SS_WORD)) && bus_be[SS_LANE];

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      rl_wr[n]     = bus_we && (word == WW'((CH_BASE + CH_STEP*n) / 4));
      cnt_wr[n]    = bus_we && (word == WW'((CH_BASE + CH_STEP*n) / 4 + 1));
      ctl_lo_wr[n] = bus_we && (word == WW'((CH_BASE + CH_STEP*n) / 4 + 2)) && bus_be[0];
      ctl_hi_wr[n] = bus_we && (word == WW'((CH_BASE + CH_STEP*n) / 4 + 2)) && bus_be[1];
      tick[n]      = run[n] && (psc_q[n] <= 3'd4) &&
                     ((pre_q[n] & psc_mask(psc_q[n])) == psc_mask(psc_q[n]));
      unf[n]       = tick[n] && (cnt_q[n] == 32'd0);
    end
  end

  assign irq = uf_q & ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (ss_wr) run <= bus_wdata[8*SS_LANE +: NCH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      cnt_q    <= '1;
      pre_q    <= '0;
      psc_q    <= '0;
      ie_q     <= '0;
      uf_q     <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        pre_q[n] <= run[n] ? pre_q[n] + 10'd1 : 10'd0;
        if (rl_wr[n]) reload_q[n] <= lanes(reload_q[n], bus_wdata, bus_be);
        if (cnt_wr[n])    cnt_q[n] <= lanes(cnt_q[n], bus_wdata, bus_be);
        else if (unf[n])  cnt_q[n] <= reload_q[n];
        else if (tick[n]) cnt_q[n] <= cnt_q[n] - 32'd1;
        if (ctl_lo_wr[n]) begin
          psc_q[n] <= bus_wdata[2:0];
          ie_q[n]  <= bus_wdata[5];
        end
        if (unf[n]) uf_q[n] <= 1'b1;
        else if (ctl_hi_wr[n] && !bus_wdata[8]) uf_q[n] <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (word == WW'(SS_WORD)) bus_rdata[8*SS_LANE +: 8] = 8'(run);
    for (int n = 0; n < NCH; n++) begin
      if (word == WW'((CH_BASE + CH_STEP*n) / 4))     bus_rdata = reload_q[n];
      if (word == WW'((CH_BASE + CH_STEP*n) / 4 + 1)) bus_rdata = cnt_q[n];
      if (word == WW'((CH_BASE + CH_STEP*n) / 4 + 2))
        bus_rdata = {16'd0, 7'd0, uf_q[n], 2'd0, ie_q[n], 2'd0, psc_q[n]};
    end
  end
endmodule

// File: rtl/ch_down_timer_chk.sv
module ch_down_timer_chk #(
  parameter int NCH = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           bus_be,
  input logic [31:0]          bus_wdata,
  input logic [NCH-1:0]       run,
  input logic [NCH-1:0]       tick,
  input logic [NCH-1:0]       uf_q,
  input logic [NCH-1:0]       cnt_wr,
  input logic [NCH-1:0]       ctl_hi_wr,
  input logic [NCH-1:0][2:0]  psc_q,
  input logic [NCH-1:0][31:0] cnt_q,
  input logic [NCH-1:0][31:0] reload_q
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // R1
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[n] && !cnt_wr[n]) |=> $stable(cnt_q[n]));
    // R5
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psc_q[n] > 3'd4) |-> !tick[n]);
    // R7
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[n] && cnt_q[n] == 32'd0 && !cnt_wr[n]) |=> (cnt_q[n] == $past(reload_q[n]) && uf_q[n]));
    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_q[n] && !ctl_hi_wr[n]) |=> uf_q[n]);
    // R10
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr[n] && bus_be == 4'hF) |=> (cnt_q[n] == $past(bus_wdata)));
  end
endmodule

bind ch_down_timer ch_down_timer_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/test_ch_down_timer.sv
module test_ch_down_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, we_leg = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_leg;
  logic [2:0]  irq;
  logic [1:0]  irq_leg;

  always #2.5 clk = ~clk;

  ch_down_timer #(.NCH(3), .LEGACY(1'b0), .AW(8)) i_ch_down_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq(irq));

  ch_down_timer #(.NCH(2), .LEGACY(1'b1), .AW(8)) i_ch_down_timer_legacy (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(we_leg), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_leg), .irq(irq_leg));

  typedef struct {bit leg; bit is_irq; logic [31:0] exp; string req;} item_t;
  item_t q[$];
  int checks = 0, failures = 0;
  bit mon_go = 1'b0, done = 1'b0;

  task automatic wr(input bit leg, input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be;
    if (leg) we_leg = 1'b1; else bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; we_leg = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input bit leg, input bit is_irq, input logic [7:0] a,
                      input logic [31:0] e, input string r);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.leg = leg; it.is_irq = is_irq; it.exp = e; it.req = r;
    q.push_back(it);
    mon_go = 1'b1;
    @(posedge clk); #2;
    mon_go = 1'b0;
  endtask

  task automatic rd(input bit leg, input logic [7:0] a, input logic [31:0] e, input string r);
    push(leg, 1'b0, a, e, r);
  endtask

  task automatic chk_irq(input logic [2:0] e, input string r);
    push(1'b0, 1'b1, 8'd0, {29'd0, e}, r);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (mon_go && q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? {29'd0, irq} : (it.leg ? rdata_leg : rdata);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    rd(0, 8'd4, 32'h0, "R11 run byte");
    rd(0, 8'd8, 32'hFFFF_FFFF, "R11 reload ch0");
    rd(0, 8'd36, 32'hFFFF_FFFF, "R11 counter ch2");
    rd(0, 8'd28, 32'h0, "R11 control ch1");
    chk_irq(3'b000, "R11 irq");
    // R3 control bits and strobes, R9 writing 1 to flag does nothing
    wr(0, 8'd16, 32'h0000_FFFF, 4'b0011);
    rd(0, 8'd16, 32'h0000_0027, "R3 control mask");
    wr(0, 8'd16, 32'h0, 4'b0001);
    rd(0, 8'd16, 32'h0, "R3 control low lane");
    // R4 divide by 4
    wr(0, 8'd12, 32'd100, 4'hF);
    wr(0, 8'd4, 32'h01, 4'b0001);
    idle(19);
    wr(0, 8'd4, 32'h00, 4'b0001);
    rd(0, 8'd12, 32'd95, "R4 div4");
    rd(0, 8'd24, 32'hFFFF_FFFF, "R1 ch1 frozen");
    // R4 divide by 16
    wr(0, 8'd16, 32'h1, 4'b0001);
    wr(0, 8'd4, 32'h01, 4'b0001);
    idle(31);
    wr(0, 8'd4, 32'h00, 4'b0001);
    rd(0, 8'd12, 32'd93, "R4 div16");
    // R5 reserved code
    wr(0, 8'd16, 32'h5, 4'b0001);
    wr(0, 8'd4, 32'h01, 4'b0001);
    idle(40);
    wr(0, 8'd4, 32'h00, 4'b0001);
    rd(0, 8'd12, 32'd93, "R5 reserved stops");
    // R1 channel 2 alone
    wr(0, 8'd36, 32'd50, 4'hF);
    wr(0, 8'd40, 32'h0, 4'b0011);
    wr(0, 8'd4, 32'h04, 4'b0001);
    idle(7);
    wr(0, 8'd4, 32'h00, 4'b0001);
    rd(0, 8'd36, 32'd48, "R1 ch2 runs");
    rd(0, 8'd12, 32'd93, "R1 ch0 frozen");
    // R6 prescaler restarts
    wr(0, 8'd16, 32'h0, 4'b0001);
    wr(0, 8'd4, 32'h01, 4'b0001);
    idle(1);
    wr(0, 8'd4, 32'h00, 4'b0001);
    wr(0, 8'd4, 32'h01, 4'b0001);
    idle(1);
    wr(0, 8'd4, 32'h00, 4'b0001);
    rd(0, 8'd12, 32'd93, "R6 prescaler reset");
    // R7 underflow reload, R8 irq
    wr(0, 8'd8, 32'h0000_1234, 4'hF);
    wr(0, 8'd12, 32'd2, 4'hF);
    wr(0, 8'd16, 32'h20, 4'b0011);
    wr(0, 8'd4, 32'h01, 4'b0001);
    idle(11);
    wr(0, 8'd4, 32'h00, 4'b0001);
    rd(0, 8'd12, 32'h0000_1234, "R7 reload");
    rd(0, 8'd16, 32'h0000_0120, "R7 flag set");
    chk_irq(3'b001, "R8 irq high");
    // R9 flag write semantics
    wr(0, 8'd16, 32'h0000_0100, 4'b0010);
    rd(0, 8'd16, 32'h0000_0120, "R9 write one keeps");
    wr(0, 8'd16, 32'h0, 4'b0010);
    rd(0, 8'd16, 32'h0000_0020, "R9 write zero clears");
    chk_irq(3'b000, "R8 irq low");
    // R9 same-cycle underflow wins
    wr(0, 8'd12, 32'd0, 4'hF);
    wr(0, 8'd4, 32'h01, 4'b0001);
    idle(3);
    wr(0, 8'd16, 32'h0, 4'b0010);
    wr(0, 8'd4, 32'h00, 4'b0001);
    rd(0, 8'd16, 32'h0000_0120, "R9 underflow wins");
    rd(0, 8'd12, 32'h0000_1234, "R7 reload from zero");
    wr(0, 8'd16, 32'h0, 4'b0011);
    // R10 counter write overrides decrement
    wr(0, 8'd12, 32'd1000, 4'hF);
    wr(0, 8'd4, 32'h01, 4'b0001);
    idle(3);
    wr(0, 8'd12, 32'd500, 4'hF);
    idle(3);
    wr(0, 8'd4, 32'h00, 4'b0001);
    rd(0, 8'd12, 32'd499, "R10 override");
    wr(0, 8'd12, 32'h0000_00AB, 4'b0001);
    rd(0, 8'd12, 32'h0000_01AB, "R3 byte strobe");
    // R1 upper run bits
    wr(0, 8'd4, 32'hFF, 4'b0001);
    rd(0, 8'd4, 32'h07, "R1 upper bits zero");
    wr(0, 8'd4, 32'h00, 4'b0001);
    // R2 legacy layout
    rd(1, 8'd2, 32'h0, "R2 legacy run byte");
    wr(1, 8'd4, 32'h0000_CAFE, 4'hF);
    rd(1, 8'd4, 32'h0000_CAFE, "R2 legacy reload ch0");
    wr(1, 8'd20, 32'd10, 4'hF);
    wr(1, 8'd24, 32'h0, 4'b0011);
    wr(1, 8'd2, 32'h0002_0000, 4'b0100);
    idle(7);
    wr(1, 8'd2, 32'h0, 4'b0100);
    rd(1, 8'd20, 32'd8, "R2 legacy ch1 count");
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule